// File: doc/BRIEF.md
# Selectable Pulse Decimation Strobe

This block takes a free-running pulse stream that is high on odd cycles and low on even cycles, giving eight pulses in a repeating frame of sixteen clock cycles. It drives a strobe that keeps a subset of those pulses. Which subset is kept depends on a 2-bit rate selector. A consumer downstream can use the strobe as a qualifier to thin out a sample stream by a fixed, frame-aligned keep/drop mask. This is not a plain divide-by-N counter.

A 4-bit frame position counter steps once per clock. The selector is sampled only on the edge that opens a new frame, so one frame never holds two patterns. The keep bit for each cycle is registered on the edge that opens that cycle. The strobe is that registered bit qualified by the live pulse input, so a kept pulse shows on the strobe in the same cycle as the pulse itself. All pins are plain control pins with no handshake.

Reset is synchronous and active high. It parks the counter on the last frame position and clears the keep bit. The first clock edge with reset low then opens frame cycle 1.

Top module: `pulse_decim_top`

## Requirements
- R1: While `rst_i` is sampled high, the keep register is cleared. From the cycle after a reset edge, `strobe_o` stays 0 until the first edge with `rst_i` low, and that edge opens frame cycle 1.
- R2: Frame cycles are numbered 1 to 16. The position advances by one on every edge outside reset and wraps from cycle 16 back to cycle 1, so the pattern repeats every 16 cycles.
- R3: With the frame selector at 0, `strobe_o` is high on cycles 1, 3, 5, 7, 9, 11, 13 and 15, so every pulse passes.
- R4: With the frame selector at 1, `strobe_o` is high only on cycles 3, 11, 1 and 9. Pairs of pulses alternate between kept and dropped.
- R5: With the frame selector at 2, `strobe_o` is high only on cycles 9 and 1, which is one pulse in each half frame.
- R6: With the frame selector at 3, `strobe_o` is high only on cycles 1 and 3, and low for cycles 4 to 16.
- R7: `sel_i` is sampled only on the edge that opens cycle 1. A change of `sel_i` in the middle of a frame leaves that frame's pattern unchanged.
- R8: `strobe_o` is high only while `pulse_i` is high. A kept cycle whose pulse is missing gives no strobe.
- R9: `strobe_o` is never high on an even frame cycle, whatever the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| pulse_i | input | 1 | Pulse stream, high on odd frame cycles |
| sel_i | input | 2 | Decimation selector, sampled at frame start |
| strobe_o | output | 1 | Kept pulses |

## Verification
On every cycle, the embedded properties check four things:
- The position counter steps by one and wraps.
- The held selector stays stable except on the frame-opening edge.
- No keep bit is ever set on an even cycle.
- The strobe is quiet after a reset edge and in the tail of a selector-3 frame.

The exact kept cycle set for each selector can only be shown by the bench's frame scenarios. The same holds for:
- the frame alignment after reset;
- the gating by a missing pulse;
- the proof that a mid-frame selector change does not alter the frame in progress.

The bench compares every output sample against a queued expectation, and also compares a 16-bit history at the end of each frame.

// File: rtl/pulse_decim_pkg.sv
package pulse_decim_pkg;
  localparam int unsigned FRAME_LEN = 16;
  localparam int unsigned POS_W = $clog2(FRAME_LEN);
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    RATE_ALL   = 2'd0,
    RATE_PAIRS = 2'd1,
    RATE_HALF  = 2'd2,
    RATE_HEAD  = 2'd3
  } rate_e;

  // k is the zero-based frame index (cycle number minus one)
  function automatic logic keep_at(input rate_e rate, input logic [POS_W-1:0] k);
    logic odd_cycle;
    odd_cycle = ~k[0];
    unique case (rate)
      RATE_ALL:   keep_at = odd_cycle;
      RATE_PAIRS: keep_at = odd_cycle & ~k[2];
      RATE_HALF:  keep_at = (k[2:0] == 3'd0);
      RATE_HEAD:  keep_at = odd_cycle & (k[POS_W-1:2] == '0);
      default:    keep_at = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/frame_pos_ctr.sv
module frame_pos_ctr
  import pulse_decim_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] pos_next_o,
  output logic             frame_open_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;

  assign frame_open_o = (pos_q == LAST_POS);
  assign pos_next_o   = frame_open_o ? '0 : pos_q + 1'b1;
  assign pos_o        = pos_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) pos_q <= LAST_POS;
    else       pos_q <= pos_next_o;
  end

  AST_POS_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (pos_q == POS_W'($past(pos_q) + 1'b1)));  // R2
  AST_POS_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (pos_q == LAST_POS) |=> (pos_q == '0));  // R2
endmodule

// File: rtl/rate_hold.sv
module rate_hold
  import pulse_decim_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             load_i,
  output rate_e            rate_q_o,
  output rate_e            rate_use_o
);
  rate_e rate_q;

  assign rate_use_o = load_i ? rate_e'(sel_i) : rate_q;
  assign rate_q_o   = rate_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       rate_q <= RATE_ALL;
    else if (load_i) rate_q <= rate_e'(sel_i);
  end

  AST_RATE_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> $stable(rate_q));  // R7
endmodule

// File: rtl/keep_lookup.sv
module keep_lookup
  import pulse_decim_pkg::*;
(
  input  rate_e            rate_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             keep_o
);
  always_comb keep_o = keep_at(rate_i, pos_i);
endmodule

// File: rtl/pulse_decim_top.sv
module pulse_decim_top
  import pulse_decim_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             pulse_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             strobe_o
);
  logic [POS_W-1:0] pos, pos_next;
  logic             frame_open;
  rate_e            rate_held, rate_use;
  logic             keep_next, keep_q;

  frame_pos_ctr u_ctr (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .pos_o        (pos),
    .pos_next_o   (pos_next),
    .frame_open_o (frame_open)
  );

  rate_hold u_rate (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sel_i      (sel_i),
    .load_i     (frame_open),
    .rate_q_o   (rate_held),
    .rate_use_o (rate_use)
  );

  keep_lookup u_lut (
    .rate_i (rate_use),
    .pos_i  (pos_next),
    .keep_o (keep_next)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) keep_q <= 1'b0;
    else       keep_q <= keep_next;
  end

  assign strobe_o = keep_q & pulse_i;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |=> !strobe_o);  // R1
  AST_EVEN_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    pos[0] |-> !keep_q);  // R9
  AST_HEAD_TAIL: assert property (@(posedge clk_i) disable iff (rst_i)
    (rate_held == RATE_HEAD && pos >= POS_W'(4)) |-> !keep_q);  // R6
  AST_HALF_SPARSE: assert property (@(posedge clk_i) disable iff (rst_i)
    (rate_held == RATE_HALF && pos[2:0] != 3'd0) |-> !keep_q);  // R5
endmodule

// File: tb/sim_pulse_decim_top.sv
module sim_pulse_decim_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pulse = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       strobe;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] hist_act, hist_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_decim_top u0 (
    .clk_i    (clk),
    .rst_i    (rst),
    .pulse_i  (pulse),
    .sel_i    (sel),
    .strobe_o (strobe)
  );

  // expected keep set written by cycle number 1..16
  function automatic bit model_keep(input logic [1:0] s, input int c);
    case (s)
      2'd0: return (c % 2) == 1;
      2'd1: return c inside {1, 3, 9, 11};
      2'd2: return c inside {1, 9};
      default: return c inside {1, 3};
    endcase
  endfunction

  // monitor: pops one expectation per cycle
  always @(negedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      hist_act = {hist_act[14:0], strobe};
      hist_exp = {hist_exp[14:0], it.exp};
      if (strobe !== it.exp) begin
        bad++;
        $display("FAIL %s strobe actual=%b expected=%b at %0t", it.tag, strobe, it.exp, $time);
      end
    end
  end

  task automatic do_reset(input logic [1:0] s, input int n);
    item_t it;
    @(negedge clk);
    rst = 1'b1; pulse = 1'b0; sel = s;
    it.exp = 1'b0; it.tag = "R1"; q.push_back(it);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pulse = 1'b1;
      it.exp = 1'b0; it.tag = "R1"; q.push_back(it);
    end
    @(negedge clk);
    rst = 1'b0; pulse = 1'b0;
    it.exp = 1'b0; it.tag = "R1"; q.push_back(it);
  endtask

  // cur: selector latched for this frame; mid: driven at cycle 8; nxt: driven at cycle 16
  task automatic run_frame(input logic [1:0] cur, input logic [1:0] mid,
                           input logic [1:0] nxt, input int drop_c, input int ncyc);
    item_t it;
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      pulse = ((c % 2) == 1) && (c != drop_c);
      if (c == 8) sel = mid;
      if (c == 16) sel = nxt;
      it.exp = model_keep(cur, c) && pulse;
      if (c == drop_c) it.tag = "R8";
      else if ((c % 2) == 0) it.tag = "R9";
      else if (c > 8 && mid != cur) it.tag = "R7";
      else case (cur)
        2'd0: it.tag = "R3";
        2'd1: it.tag = "R4";
        2'd2: it.tag = "R5";
        default: it.tag = "R6";
      endcase
      q.push_back(it);
    end
    if (ncyc == 16) begin
      @(negedge clk);
      #3;
      total++;
      if (hist_act !== hist_exp) begin
        bad++;
        $display("FAIL R2 frame history actual=%h expected=%h", hist_act, hist_exp);
      end
      // roll back the extra negedge: drive the next frame's cycle 1 is handled by caller
    end
  endtask

  // full frame helper keeping alignment: history check happens inside cycle 1 of next frame
  task automatic frame(input logic [1:0] cur, input logic [1:0] mid,
                       input logic [1:0] nxt, input int drop_c);
    item_t it;
    for (int c = 1; c <= 16; c++) begin
      @(negedge clk);
      pulse = ((c % 2) == 1) && (c != drop_c);
      if (c == 8) sel = mid;
      if (c == 16) sel = nxt;
      it.exp = model_keep(cur, c) && pulse;
      if (c == drop_c) it.tag = "R8";
      else if ((c % 2) == 0) it.tag = "R9";
      else if (c > 8 && mid != cur) it.tag = "R7";
      else case (cur)
        2'd0: it.tag = "R3";
        2'd1: it.tag = "R4";
        2'd2: it.tag = "R5";
        default: it.tag = "R6";
      endcase
      q.push_back(it);
    end
    #4;
    total++;
    if (hist_act !== hist_exp) begin
      bad++;
      $display("FAIL R2 frame history actual=%h expected=%h", hist_act, hist_exp);
    end
  endtask

  initial begin
    hist_act = '0; hist_exp = '0;
    repeat (3) @(posedge clk);
    do_reset(2'd0, 2);
    frame(2'd0, 2'd3, 2'd1, 0);   // R3, R7 (mid change to 3 ignored)
    frame(2'd1, 2'd2, 2'd2, 0);   // R4, R7
    frame(2'd2, 2'd0, 2'd3, 0);   // R5, R7
    frame(2'd3, 2'd1, 2'd1, 0);   // R6, R7
    frame(2'd1, 2'd1, 2'd3, 9);   // R8: kept cycle 9 with pulse missing
    frame(2'd3, 2'd3, 2'd0, 1);   // R8 on cycle 1, R6
    frame(2'd0, 2'd0, 2'd0, 0);   // R2 wrap, R3 again
    run_frame(2'd0, 2'd0, 2'd0, 0, 5);  // partial frame, then reset
    do_reset(2'd2, 3);            // R1: restart latches selector 2
    frame(2'd2, 2'd2, 2'd1, 0);   // R1 alignment to cycle 1, R5
    frame(2'd1, 2'd1, 2'd1, 0);   // R4
    @(negedge clk);
    #4;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule